// File: doc/BRIEF.md
# Task Switch Sequencer

This block carries out a protected-mode hardware task switch as a multi-cycle sequence. A request names one of four switch kinds: jump, call, interrupt through a task gate, or interrupt-return while the nested-task flag is set. The requester also supplies the fields of the target descriptor (present, limit, privilege level), the effective privilege of the request, the live EFLAGS and register image, and a long-mode flag.

The sequencer checks the request and reports a fault cause, or it goes through the switch. A switch saves the outgoing image into the old task's record, updates the busy bits in a small descriptor table, writes the back link when the new task is nested, loads the task register and reads back the new task's image. Each record lives in a word-wide store inside the block. The back link lets nested tasks return in order along a chain. The busy rule stops any task from being entered a second time.

The sequence moves one store word per cycle. A successful switch takes a fixed 2*NREG+5 cycles from the request edge. The requester holds every input stable until `done_o` or `fault_o` pulses.

Top module: `tswitch_seq`

## Requirements
- R1: A request is taken only when the block is idle. The kind codes are 0 jump, 1 call, 2 interrupt and 3 return. A return request whose EFLAGS bit 14 (nested flag) is 0 is ignored: it raises no pulse and changes neither the task register nor the busy bits.
- R2: A rejected request gives `fault_o` high for exactly one cycle, the second cycle after the request edge. `cause_o` holds the cause in that cycle. After a fault, the task register, the busy bits and the stored records are as they were before the request.
- R3: For jump and call, the request faults with cause 2 when the effective privilege is numerically greater than the target privilege level. Interrupt and return skip this test.
- R4: A target whose present bit is 0 faults with cause 3. A target whose limit is below 0x67 faults with cause 4. A limit of exactly 0x67 is accepted.
- R5: For jump, call and interrupt, the target's busy bit must be 0. For return, it must be 1. A mismatch faults with cause 5, so a call into a task already on the nested chain is refused.
- R6: A switch clears the old task's busy bit for jump and return and keeps it set for call and interrupt. It sets the new task's busy bit for jump, call and interrupt. The busy bits change NREG+3 cycles after the request edge.
- R7: A switch saves the input EFLAGS and registers into the old task's record. For a return, it saves them with bit 14 cleared. A later switch back to that task reloads them.
- R8: The loaded EFLAGS has bit 14 forced to 1 for call and interrupt, and taken as stored for jump and return.
- R9: Call and interrupt write the old task number into the new task's link word. A return targets the task named by the current task's link word.
- R10: The task register takes the new task number NREG+4 cycles after the request edge. `done_o` pulses for one cycle 2*NREG+5 cycles after the request edge, with the new image on `new_eflags_o` and `new_regs_o`.
- R11: While `long_mode_i` is high, any request that R1 does not ignore faults with cause 1. Cause 1 takes priority over causes 2, 3, 4 and 5, which take priority in that order.
- R12: After reset, the task register is 0, only task 0 is busy, every record word is 0, and all pulses and image outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Switch request, one cycle |
| kind_i | input | 2 | Switch kind code |
| tgt_sel_i | input | SELW | Target task number (jump, call, interrupt) |
| cpl_i | input | 2 | Effective privilege of the request |
| dpl_i | input | 2 | Target descriptor privilege level |
| present_i | input | 1 | Target descriptor present bit |
| limit_i | input | LIMW | Target descriptor limit |
| long_mode_i | input | 1 | Long mode active |
| eflags_i | input | DW | Outgoing EFLAGS |
| regs_i | input | NREG*DW | Outgoing register image, word 0 in the low bits |
| done_o | output | 1 | Switch complete pulse |
| fault_o | output | 1 | Fault pulse |
| cause_o | output | 3 | Fault cause code |
| tr_o | output | SELW | Task register |
| busy_o | output | NTASK | Busy bit of each task |
| new_eflags_o | output | DW | Loaded EFLAGS |
| new_regs_o | output | NREG*DW | Loaded register image |

## Verification
The properties assume that the descriptor fields, EFLAGS and the register image stay constant from the request edge until the done or fault pulse. They also assume that `req_i` is asserted only for a single cycle while the block is idle. The bench keeps within this by driving every input at a falling edge and holding it through the whole sequence. It lowers the request after the first rising edge and does not issue the next request until the pulse has been seen. The stimulus never uses a return whose link names the current task, a case the properties do not cover.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic [1:0] {K_JMP = 2'd0, K_CALL = 2'd1, K_INT = 2'd2, K_IRET = 2'd3} kind_e;
  typedef enum logic [2:0] {C_NONE = 3'd0, C_LONG = 3'd1, C_PRIV = 3'd2, C_NPRES = 3'd3,
                            C_LIMIT = 3'd4, C_BUSY = 3'd5} cause_e;
  typedef enum logic [2:0] {S_IDLE = 3'd0, S_CHECK = 3'd1, S_SAVE = 3'd2, S_BUSY = 3'd3,
                            S_TRLD = 3'd4, S_LOAD = 3'd5} state_e;
endpackage

// File: rtl/tsw_check.sv
module tsw_check import tsw_pkg::*; #(
  parameter int LIMW    = 20,
  parameter int MIN_LIM = 'h67
) (
  input  kind_e            kind,
  input  logic [1:0]       cpl,
  input  logic [1:0]       dpl,
  input  logic             present,
  input  logic [LIMW-1:0]  limit,
  input  logic             long_mode,
  input  logic             tgt_busy,
  output cause_e           cause
);
  logic priv_bad, busy_bad;

  always_comb begin
    priv_bad = (kind == K_JMP || kind == K_CALL) && (cpl > dpl);
    busy_bad = (kind == K_IRET) ? !tgt_busy : tgt_busy;
    if (long_mode)                   cause = C_LONG;
    else if (priv_bad)               cause = C_PRIV;
    else if (!present)               cause = C_NPRES;
    else if (limit < LIMW'(MIN_LIM)) cause = C_LIMIT;
    else if (busy_bad)               cause = C_BUSY;
    else                             cause = C_NONE;
  end
endmodule

// File: rtl/tsw_busy.sv
module tsw_busy #(
  parameter int NTASK = 8,
  localparam int SELW = $clog2(NTASK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [SELW-1:0]  clr_idx,
  input  logic             set_en,
  input  logic [SELW-1:0]  set_idx,
  output logic [NTASK-1:0] busy
);
  for (genvar t = 0; t < NTASK; t++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_idx == SELW'(t));
    assign hit_clr = clr_en && (clr_idx == SELW'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                busy[t] <= (t == 0);
      else if (hit_set)          busy[t] <= 1'b1;
      else if (hit_clr)          busy[t] <= 1'b0;
    end
  end
endmodule

// File: rtl/tsw_store.sv
module tsw_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    logic wen;
    assign wen = we && (waddr == AW'(a));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[a] <= '0;
      else if (wen) mem[a] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tswitch_seq.sv
module tswitch_seq import tsw_pkg::*; #(
  parameter int NTASK   = 8,
  parameter int NREG    = 4,
  parameter int DW      = 32,
  parameter int LIMW    = 20,
  parameter int NT_BIT  = 14,
  parameter int MIN_LIM = 'h67,
  localparam int SELW   = $clog2(NTASK),
  localparam int RECW   = NREG + 2,
  localparam int OFFW   = $clog2(RECW),
  localparam int DEPTH  = NTASK << OFFW,
  localparam int AW     = SELW + OFFW,
  localparam int CNTW   = $clog2(NREG + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_i,
  input  logic [1:0]           kind_i,
  input  logic [SELW-1:0]      tgt_sel_i,
  input  logic [1:0]           cpl_i,
  input  logic [1:0]           dpl_i,
  input  logic                 present_i,
  input  logic [LIMW-1:0]      limit_i,
  input  logic                 long_mode_i,
  input  logic [DW-1:0]        eflags_i,
  input  logic [NREG*DW-1:0]   regs_i,
  output logic                 done_o,
  output logic                 fault_o,
  output logic [2:0]           cause_o,
  output logic [SELW-1:0]      tr_o,
  output logic [NTASK-1:0]     busy_o,
  output logic [DW-1:0]        new_eflags_o,
  output logic [NREG*DW-1:0]   new_regs_o
);
  state_e               state_q, state_d;
  logic [CNTW-1:0]      cnt_q, cnt_d;
  kind_e                kind_q, kind_d;
  logic [SELW-1:0]      tgt_q, tgt_d, tr_q, tr_d;
  logic                 done_q, done_d, fault_q, fault_d;
  cause_e               cause_q, cause_d;
  logic [DW-1:0]        nefl_q, nefl_d;
  logic [NREG*DW-1:0]   nregs_q, nregs_d;

  logic                 we;
  logic [AW-1:0]        waddr, raddr;
  logic [DW-1:0]        wdata, rdata;
  logic                 clr_en, set_en;
  cause_e               chk_cause;
  logic [OFFW-1:0]      off_w;
  logic [DW-1:0]        reg_word, efl_out;
  logic                 nested;

  tsw_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata));

  tsw_busy #(.NTASK(NTASK)) u_busy (
    .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .clr_idx(tr_q),
    .set_en(set_en), .set_idx(tgt_q), .busy(busy_o));

  tsw_check #(.LIMW(LIMW), .MIN_LIM(MIN_LIM)) u_check (
    .kind(kind_q), .cpl(cpl_i), .dpl(dpl_i), .present(present_i),
    .limit(limit_i), .long_mode(long_mode_i), .tgt_busy(busy_o[tgt_q]),
    .cause(chk_cause));

  // word offset inside a record: 0 link, 1 EFLAGS, 2.. registers
  assign off_w  = OFFW'(cnt_q) + OFFW'(1);
  assign nested = (kind_q == K_CALL) || (kind_q == K_INT);

  always_comb begin
    reg_word = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(cnt_q) == i + 1) reg_word = regs_i[i*DW +: DW];
    efl_out = eflags_i;
    if (kind_q == K_IRET) efl_out[NT_BIT] = 1'b0;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    kind_d  = kind_q;
    tgt_d   = tgt_q;
    tr_d    = tr_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    cause_d = C_NONE;
    nefl_d  = nefl_q;
    nregs_d = nregs_q;
    we      = 1'b0;
    waddr   = '0;
    wdata   = '0;
    raddr   = {tr_q, OFFW'(0)};
    clr_en  = 1'b0;
    set_en  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_i && !(kind_e'(kind_i) == K_IRET && !eflags_i[NT_BIT])) begin
          kind_d  = kind_e'(kind_i);
          tgt_d   = (kind_e'(kind_i) == K_IRET) ? rdata[SELW-1:0] : tgt_sel_i;
          state_d = S_CHECK;
        end
      end
      S_CHECK: begin
        if (chk_cause != C_NONE) begin
          fault_d = 1'b1;
          cause_d = chk_cause;
          state_d = S_IDLE;
        end else begin
          cnt_d   = '0;
          state_d = S_SAVE;
        end
      end
      S_SAVE: begin
        we    = 1'b1;
        waddr = {tr_q, off_w};
        wdata = (cnt_q == '0) ? efl_out : reg_word;
        if (int'(cnt_q) == NREG) state_d = S_BUSY;
        else                     cnt_d   = cnt_q + CNTW'(1);
      end
      S_BUSY: begin
        clr_en  = (kind_q == K_JMP) || (kind_q == K_IRET);
        set_en  = (kind_q != K_IRET);
        we      = nested;
        waddr   = {tgt_q, OFFW'(0)};
        wdata   = DW'(tr_q);
        state_d = S_TRLD;
      end
      S_TRLD: begin
        tr_d    = tgt_q;
        cnt_d   = '0;
        state_d = S_LOAD;
      end
      S_LOAD: begin
        raddr = {tgt_q, off_w};
        if (cnt_q == '0) begin
          nefl_d = rdata;
          if (nested) nefl_d[NT_BIT] = 1'b1;
        end
        for (int i = 0; i < NREG; i++)
          if (int'(cnt_q) == i + 1) nregs_d[i*DW +: DW] = rdata;
        if (int'(cnt_q) == NREG) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          cnt_d = cnt_q + CNTW'(1);
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      kind_q  <= K_JMP;
      tgt_q   <= '0;
      tr_q    <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= C_NONE;
      nefl_q  <= '0;
      nregs_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
      tgt_q   <= tgt_d;
      tr_q    <= tr_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      cause_q <= cause_d;
      if (state_q == S_LOAD) begin
        nefl_q  <= nefl_d;
        nregs_q <= nregs_d;
      end
    end
  end

  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign cause_o      = cause_q;
  assign tr_o         = tr_q;
  assign new_eflags_o = nefl_q;
  assign new_regs_o   = nregs_q;
endmodule

// File: rtl/tsw_seq_chk.sv
module tsw_seq_chk import tsw_pkg::*; #(
  parameter int NTASK  = 8,
  parameter int DW     = 32,
  parameter int NT_BIT = 14,
  localparam int SELW  = $clog2(NTASK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic [1:0]       kind_i,
  input logic             long_mode_i,
  input logic [DW-1:0]    eflags_i,
  input logic             done_o,
  input logic             fault_o,
  input logic [2:0]       cause_o,
  input logic [SELW-1:0]  tr_o,
  input logic [NTASK-1:0] busy_o,
  input logic [DW-1:0]    new_eflags_o,
  input logic [2:0]       state_q,
  input logic [1:0]       kind_q
);
  logic take, plain_ret;
  assign plain_ret = (kind_i == 2'd3) && !eflags_i[NT_BIT];
  assign take      = (state_q == 3'(S_IDLE)) && req_i;

  a_r10_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o));

  a_r2_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o);

  a_r2_fault_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> ($stable(tr_o) && $stable(busy_o)));

  a_r11_long_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (take && long_mode_i && !plain_ret) |=> ##1 (fault_o && cause_o == 3'd1));

  a_r1_plain_return: assert property (@(posedge clk) disable iff (!rst_n)
    (take && plain_ret) |=> ($stable(tr_o) && $stable(busy_o) && !done_o && !fault_o));

  a_r6_new_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o[tr_o]);

  a_r8_nt_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (kind_q == 2'd1 || kind_q == 2'd2)) |-> new_eflags_o[NT_BIT]);
endmodule

bind tswitch_seq tsw_seq_chk #(.NTASK(NTASK), .DW(DW), .NT_BIT(NT_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i),
  .long_mode_i(long_mode_i), .eflags_i(eflags_i), .done_o(done_o),
  .fault_o(fault_o), .cause_o(cause_o), .tr_o(tr_o), .busy_o(busy_o),
  .new_eflags_o(new_eflags_o), .state_q(state_q), .kind_q(kind_q));

// File: tb/tswitch_seq_test.sv
`timescale 1ns/1ps
module tswitch_seq_test;
  localparam int NTASK = 8;
  localparam int NREG  = 4;
  localparam int DW    = 32;
  localparam int LIMW  = 20;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_i;
  logic [1:0]        kind_i;
  logic [2:0]        tgt_sel_i;
  logic [1:0]        cpl_i, dpl_i;
  logic              present_i;
  logic [LIMW-1:0]   limit_i;
  logic              long_mode_i;
  logic [DW-1:0]     eflags_i;
  logic [NREG*DW-1:0] regs_i;
  logic              done_o, fault_o;
  logic [2:0]        cause_o;
  logic [2:0]        tr_o;
  logic [NTASK-1:0]  busy_o;
  logic [DW-1:0]     new_eflags_o;
  logic [NREG*DW-1:0] new_regs_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference state
  logic [DW-1:0] m_rec [NTASK][NREG+2];
  logic [NTASK-1:0] m_busy;
  logic [2:0] m_tr;

  always #2 clk = ~clk;

  tswitch_seq uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .kind_i(kind_i),
    .tgt_sel_i(tgt_sel_i), .cpl_i(cpl_i), .dpl_i(dpl_i),
    .present_i(present_i), .limit_i(limit_i), .long_mode_i(long_mode_i),
    .eflags_i(eflags_i), .regs_i(regs_i), .done_o(done_o), .fault_o(fault_o),
    .cause_o(cause_o), .tr_o(tr_o), .busy_o(busy_o),
    .new_eflags_o(new_eflags_o), .new_regs_o(new_regs_o));

  task automatic chk(input bit ok, input string rq, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic sw(input int kind, input int sel, input int cpl, input int dpl,
                    input bit pres, input int lim, input bit lm,
                    input logic [DW-1:0] efl, input logic [NREG*DW-1:0] regs);
    bit ignored, ok;
    int tgt, cause, last;
    logic [NTASK-1:0] nb;
    logic [DW-1:0] xefl;
    logic [NREG*DW-1:0] xregs;
    string ctag;
    ignored = (kind == 3) && !efl[14];
    tgt = (kind == 3) ? int'(m_rec[m_tr][0][2:0]) : sel;
    if (lm) cause = 1;
    else if (kind < 2 && cpl > dpl) cause = 2;
    else if (!pres) cause = 3;
    else if (lim < 'h67) cause = 4;
    else if ((kind == 3) ? !m_busy[tgt] : m_busy[tgt]) cause = 5;
    else cause = 0;
    ctag = (cause == 1) ? "R11" : (cause == 2) ? "R3" : (cause == 5) ? "R5" : "R4";
    ok = !ignored && cause == 0;
    nb = m_busy;
    if (ok) begin
      // save outgoing image (R7), nested flag cleared on return
      m_rec[m_tr][1] = efl;
      if (kind == 3) m_rec[m_tr][1][14] = 1'b0;
      for (int k = 0; k < NREG; k++) m_rec[m_tr][2+k] = regs[k*DW +: DW];
      if (kind == 0 || kind == 3) nb[m_tr] = 1'b0;
      if (kind != 3) nb[tgt] = 1'b1;
      if (kind == 1 || kind == 2) m_rec[tgt][0] = DW'(m_tr);  // back link R9
      xefl = m_rec[tgt][1];
      if (kind == 1 || kind == 2) xefl[14] = 1'b1;
      for (int k = 0; k < NREG; k++) xregs[k*DW +: DW] = m_rec[tgt][2+k];
    end
    @(negedge clk);
    req_i = 1'b1; kind_i = 2'(kind); tgt_sel_i = 3'(sel); cpl_i = 2'(cpl);
    dpl_i = 2'(dpl); present_i = pres; limit_i = LIMW'(lim); long_mode_i = lm;
    eflags_i = efl; regs_i = regs;
    last = ok ? 2*NREG + 6 : 3;
    for (int i = 0; i <= last; i++) begin
      logic [NTASK-1:0] eb;
      logic [2:0] et;
      @(negedge clk);
      req_i = 1'b0;
      eb = (ok && i >= NREG + 3) ? nb : m_busy;
      et = (ok && i >= NREG + 4) ? 3'(tgt) : m_tr;
      if (ignored) begin
        chk(busy_o == eb && tr_o == et && !done_o && !fault_o, "R1 ignored return",
            {busy_o, tr_o, done_o, fault_o}, {eb, et, 2'b00});
      end else begin
        chk(busy_o == eb, "R6 busy bits", busy_o, eb);
        chk(tr_o == et, (kind == 3) ? "R9 task register" : "R10 task register", tr_o, et);
        chk(done_o == (ok && i == 2*NREG + 5), "R10 done pulse", done_o, ok && i == 2*NREG + 5);
        chk(fault_o == (!ok && i == 1), "R2 fault pulse", fault_o, !ok && i == 1);
        if (!ok && i == 1) chk(cause_o == 3'(cause), ctag, cause_o, cause);
        if (ok && i == 2*NREG + 5) begin
          chk(new_eflags_o == xefl, "R8 loaded EFLAGS", new_eflags_o, xefl);
          chk(new_regs_o == xregs, "R7 loaded registers", new_regs_o, xregs);
        end
      end
    end
    if (ok) begin
      m_busy = nb;
      m_tr = 3'(tgt);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; kind_i = '0; tgt_sel_i = '0; cpl_i = '0; dpl_i = '0;
    present_i = 1'b0; limit_i = '0; long_mode_i = 1'b0; eflags_i = '0; regs_i = '0;
    for (int t = 0; t < NTASK; t++)
      for (int w = 0; w < NREG + 2; w++) m_rec[t][w] = '0;
    m_busy = 8'h01;
    m_tr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(tr_o == 0 && busy_o == 8'h01, "R12 reset TR/busy", {tr_o, busy_o}, {3'd0, 8'h01});
    chk(!done_o && !fault_o && new_eflags_o == 0 && new_regs_o == 0, "R12 reset outputs",
        {done_o, fault_o, new_eflags_o}, 0);

    // R4 boundary: limit 0x67 accepted; jump loads zeroed record (R12)
    sw(0, 1, 0, 0, 1, 'h67, 0, 32'h0000_0202, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
    // call 1 -> 2, nested flag forced (R8), link written (R9)
    sw(1, 2, 1, 2, 1, 'h100, 0, 32'h0000_0046, {32'hB3, 32'hB2, 32'hB1, 32'hB0});
    // interrupt 2 -> 3 with privilege above dpl: no privilege test for interrupts (R3)
    sw(2, 3, 3, 0, 1, 'h80, 0, 32'h0000_4202, {32'hC3, 32'hC2, 32'hC1, 32'hC0});
    // call into busy task on the chain (R5)
    sw(1, 1, 0, 3, 1, 'h80, 0, 32'h0000_4002, {32'hD3, 32'hD2, 32'hD1, 32'hD0});
    // return without nested flag ignored (R1)
    sw(3, 0, 0, 0, 1, 'h80, 0, 32'h0000_0002, {32'hE3, 32'hE2, 32'hE1, 32'hE0});
    // return 3 -> 2 along link (R9), saved flag cleared (R7)
    sw(3, 0, 0, 0, 1, 'h80, 0, 32'h0000_4097, {32'hF3, 32'hF2, 32'hF1, 32'hF0});
    // return 2 -> 1
    sw(3, 0, 0, 0, 1, 'h80, 0, 32'h0000_4013, {32'h13, 32'h12, 32'h11, 32'h10});
    // privilege fault on jump (R3), then priority priv over not-present (R11)
    sw(0, 4, 3, 0, 1, 'h80, 0, 32'h0000_0002, {32'h23, 32'h22, 32'h21, 32'h20});
    sw(1, 4, 3, 1, 0, 'h10, 0, 32'h0000_0002, {32'h23, 32'h22, 32'h21, 32'h20});
    // not present (R4) and limit one below (R4)
    sw(0, 4, 0, 0, 0, 'h80, 0, 32'h0000_0002, {32'h33, 32'h32, 32'h31, 32'h30});
    sw(1, 4, 0, 0, 1, 'h66, 0, 32'h0000_0002, {32'h33, 32'h32, 32'h31, 32'h30});
    // long mode faults first, even with other faults (R11)
    sw(0, 4, 3, 0, 0, 'h10, 1, 32'h0000_0002, {32'h43, 32'h42, 32'h41, 32'h40});
    sw(3, 0, 0, 0, 1, 'h80, 1, 32'h0000_4002, {32'h43, 32'h42, 32'h41, 32'h40});
    // interrupt 1 -> 4, then jump 4 -> 3 reloads image saved with flag cleared (R7)
    sw(2, 4, 0, 0, 1, 'h67, 0, 32'h0000_0282, {32'h53, 32'h52, 32'h51, 32'h50});
    sw(0, 3, 0, 3, 1, 'h67, 0, 32'h0000_4246, {32'h63, 32'h62, 32'h61, 32'h60});
    // return from 3: link of 3 is 2, which is no longer busy (R5)
    sw(3, 0, 0, 0, 1, 'h80, 0, 32'h0000_4002, {32'h73, 32'h72, 32'h71, 32'h70});

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule